// File: doc/BRIEF.md
# Multiframe Yellow Alarm Integrator

This block watches the remote-alarm indication carried in the signalling timeslot of received E1 multiframes and turns it into a debounced alarm. Time is cut into back-to-back observation windows of 32 frame strobes, which is 4 ms at 125 us per frame. A window counts as a hit if at least one qualified yellow sample appeared in it. Qualified means the yellow bit was high together with both the frame strobe and the multiframe-start strobe.

Window verdicts feed a saturating up/down integrator. The alarm is declared when the integrator climbs to 80. It is withdrawn only when the integrator falls back to 0, so short gaps do not toggle it.

Every change of the alarm latches a change-of-state flag. The flag is cleared by a status read when clear-on-read mode is selected, or at any time by a write with a one in the data bit. The interrupt output follows the flag, gated by a per-alarm enable and a block-level enable.

Top module: `myel_integrator`

## Requirements
- R1: A window spans exactly 32 frame strobes. It is a hit if any qualified sample occurred in it, including a single sample on frame 16 only.
- R2: A hit window raises the integrator by one, saturating at 80. The alarm output rises on the rising edge that follows the edge sampling the window's 32nd frame strobe, when the count reaches 80.
- R3: A miss window lowers the integrator by one, saturating at 0. A declared alarm stays high while the count is above 0 and falls, with the same latency as R2, when the count reaches 0.
- R4: `yel_bit` is ignored unless `frame_stb` and `mf_start` are both high in the same cycle.
- R5: Each alarm change, rising or falling, sets `cos_flag` one clock after `alarm` changes.
- R6: With `rur_mode`=1 a `stat_rd` pulse clears `cos_flag`, and with `rur_mode`=0 it has no effect. In either mode, `stat_wr` with `stat_wdata`=1 clears the flag, while `stat_wdata`=0 leaves it unchanged.
- R7: If a set and a clear of `cos_flag` fall in the same cycle, the flag is set.
- R8: `irq` equals `cos_flag` AND `cos_irq_en` AND `blk_irq_en`, combinationally.
- R9: A synchronous active-low reset zeroes the window position, the integrator, `alarm`, `cos_flag` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| mf_start | input | 1 | High with the frame strobe of a multiframe's first frame |
| yel_bit | input | 1 | Extracted multiframe yellow bit |
| rur_mode | input | 1 | 1: a status read clears the change flag |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Write data; 1 clears the change flag |
| cos_irq_en | input | 1 | Per-alarm interrupt enable |
| blk_irq_en | input | 1 | Block-level alarm interrupt enable |
| alarm | output | 1 | Debounced multiframe yellow alarm |
| cos_flag | output | 1 | Alarm change-of-state flag |
| irq | output | 1 | Interrupt request |

## Verification
The latencies are fixed. The window verdict is registered on the edge that samples the 32nd strobe. `alarm` moves one edge later and `cos_flag` one edge after that. `irq` and a flag clear follow their inputs combinationally and one edge later, respectively. The bench runs a behavioural model that applies these delays in stage order on each rising edge. It compares all three outputs at every falling edge, with inputs driven 1 ns after the rising edge. The directed checks poll falling edges for the alarm change and then sample the flag one cycle later.

// File: rtl/myel_pkg.sv
`timescale 1ns/1ps
// Shared types for the multiframe yellow alarm integrator.
package myel_pkg;
    // Verdict of one observation window, valid for a single cycle.
    typedef struct packed {
        logic valid;  // window just closed
        logic hit;    // a qualified yellow sample occurred in it
    } win_verdict_t;
endpackage

// File: rtl/myel_window.sv
`timescale 1ns/1ps
// Observation window timer.
// Counts frame strobes into windows of WIN_FRAMES frames and reports whether a
// qualified yellow sample (yellow bit with frame and multiframe-start strobes)
// occurred in each one. Assumes WIN_FRAMES >= 2.
module myel_window import myel_pkg::*; #(
    parameter int WIN_FRAMES = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_stb,
    input  logic         mf_start,
    input  logic         yel_bit,
    output win_verdict_t verdict
);
    localparam int FW = $clog2(WIN_FRAMES);
    localparam logic [FW-1:0] LAST = FW'(WIN_FRAMES - 1);

    logic [FW-1:0] fcnt;
    logic          seen;
    logic          sample;

    // Qualify the yellow bit with both strobes.
    always_comb sample = frame_stb & mf_start & yel_bit;

    // Advance the frame position and close the window on its last frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt    <= '0;
            seen    <= 1'b0;
            verdict <= '0;
        end else begin
            verdict <= '0;
            if (frame_stb) begin
                if (fcnt == LAST) begin
                    fcnt    <= '0;
                    seen    <= 1'b0;
                    verdict <= '{valid: 1'b1, hit: seen | sample};
                end else begin
                    fcnt <= fcnt + FW'(1);
                    seen <= seen | sample;
                end
            end
        end
    end

    AST_VERDICT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.valid |-> $past(frame_stb)); // R1
endmodule

// File: rtl/myel_integ.sv
`timescale 1ns/1ps
// Up/down window integrator with hysteresis.
// A hit window counts up and a miss counts down, saturating at DECLARE_CNT and 0.
// The alarm is declared at DECLARE_CNT and removed at 0. alarm_chg pulses on the
// edge on which the alarm changes.
module myel_integ import myel_pkg::*; #(
    parameter int DECLARE_CNT = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  win_verdict_t verdict,
    output logic         alarm,
    output logic         alarm_chg
);
    localparam int CW = $clog2(DECLARE_CNT + 1);
    localparam logic [CW-1:0] TOP = CW'(DECLARE_CNT);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          alarm_nxt;

    // Saturating count step and hysteresis decision.
    always_comb begin
        cnt_nxt = cnt;
        if (verdict.valid) begin
            if (verdict.hit) cnt_nxt = (cnt == TOP) ? cnt : cnt + CW'(1);
            else             cnt_nxt = (cnt == '0)  ? cnt : cnt - CW'(1);
        end
        if (cnt_nxt == TOP)      alarm_nxt = 1'b1;
        else if (cnt_nxt == '0)  alarm_nxt = 1'b0;
        else                     alarm_nxt = alarm;
    end

    // Register the count, the alarm and the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            alarm     <= 1'b0;
            alarm_chg <= 1'b0;
        end else begin
            cnt       <= cnt_nxt;
            alarm     <= alarm_nxt;
            alarm_chg <= alarm_nxt ^ alarm;
        end
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP); // R2
    AST_DECLARE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> cnt == TOP); // R2
    AST_REMOVE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> cnt == '0); // R3
    AST_ALARM_ONLY_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict.valid |=> $stable(alarm)); // R3
endmodule

// File: rtl/myel_status.sv
`timescale 1ns/1ps
// Change-of-state flag and interrupt gating.
// The flag sets on an alarm change and clears on a read in clear-on-read mode or
// on a write of one. A set beats a clear in the same cycle.
module myel_status (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_chg,
    input  logic rur_mode,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic stat_wdata,
    input  logic cos_irq_en,
    input  logic blk_irq_en,
    output logic cos_flag,
    output logic irq
);
    logic clr;

    // Either clearing path.
    always_comb clr = (stat_wr & stat_wdata) | (stat_rd & rur_mode);

    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         cos_flag <= 1'b0;
        else if (alarm_chg) cos_flag <= 1'b1;
        else if (clr)       cos_flag <= 1'b0;
    end

    // Gate the interrupt with both enables.
    always_comb irq = cos_flag & cos_irq_en & blk_irq_en;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_chg |=> cos_flag); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_chg && clr) |=> !cos_flag); // R6
    AST_FLAG_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cos_flag) |-> $past(alarm_chg)); // R5
endmodule

// File: rtl/myel_integrator.sv
`timescale 1ns/1ps
// Multiframe yellow alarm integrator, top level.
// Chains the window timer, the integrator and the status/interrupt stage.
// Assumes frame_stb pulses for one cycle per received frame.
module myel_integrator import myel_pkg::*; #(
    parameter int WIN_FRAMES  = 32,
    parameter int DECLARE_CNT = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic mf_start,
    input  logic yel_bit,
    input  logic rur_mode,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic stat_wdata,
    input  logic cos_irq_en,
    input  logic blk_irq_en,
    output logic alarm,
    output logic cos_flag,
    output logic irq
);
    win_verdict_t verdict;
    logic         alarm_chg;

    myel_window #(.WIN_FRAMES(WIN_FRAMES)) u_win (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .mf_start(mf_start), .yel_bit(yel_bit), .verdict(verdict)
    );

    myel_integ #(.DECLARE_CNT(DECLARE_CNT)) u_integ (
        .clk(clk), .rst_n(rst_n), .verdict(verdict),
        .alarm(alarm), .alarm_chg(alarm_chg)
    );

    myel_status u_stat (
        .clk(clk), .rst_n(rst_n), .alarm_chg(alarm_chg),
        .rur_mode(rur_mode), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .cos_irq_en(cos_irq_en),
        .blk_irq_en(blk_irq_en), .cos_flag(cos_flag), .irq(irq)
    );
endmodule

// File: tb/sim_myel_integrator.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared on every clock, plus directed checks.
module sim_myel_integrator;
    localparam int PER = 4;  // 250 MHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 0, mf_start = 0, yel_bit = 0;
    logic rur_mode = 0, stat_rd = 0, stat_wr = 0, stat_wdata = 0;
    logic cos_irq_en = 0, blk_irq_en = 0;
    logic alarm, cos_flag, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(PER/2) clk = ~clk;

    myel_integrator u0 (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mf_start(mf_start),
        .yel_bit(yel_bit), .rur_mode(rur_mode), .stat_rd(stat_rd),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .cos_irq_en(cos_irq_en),
        .blk_irq_en(blk_irq_en), .alarm(alarm), .cos_flag(cos_flag), .irq(irq)
    );

    // Reference model state.
    int m_frames = 0, m_cnt = 0;
    bit m_seen = 0, m_wv = 0, m_wh = 0, m_alarm = 0, m_chg = 0, m_cos = 0;

    // Behavioural model: stages updated last-to-first so each uses last cycle's values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_frames = 0; m_cnt = 0; m_seen = 0; m_wv = 0; m_wh = 0;
            m_alarm = 0; m_chg = 0; m_cos = 0;
        end else begin
            if (m_chg) m_cos = 1;
            else if ((stat_wr && stat_wdata) || (stat_rd && rur_mode)) m_cos = 0;
            m_chg = 0;
            if (m_wv) begin
                bit na;
                if (m_wh) m_cnt = (m_cnt < 80) ? m_cnt + 1 : 80;
                else      m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
                na = (m_cnt == 80) ? 1'b1 : (m_cnt == 0) ? 1'b0 : m_alarm;
                m_chg = (na != m_alarm);
                m_alarm = na;
            end
            m_wv = 0;
            if (frame_stb) begin
                bit q;
                q = mf_start && yel_bit;
                if (m_frames == 31) begin
                    m_wv = 1; m_wh = m_seen || q; m_frames = 0; m_seen = 0;
                end else begin
                    m_frames++; m_seen = m_seen || q;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(alarm === m_alarm, "R2 alarm vs model", alarm, m_alarm);
            chk(cos_flag === m_cos, "R5 cos_flag vs model", cos_flag, m_cos);
            chk(irq === (m_cos && cos_irq_en && blk_irq_en), "R8 irq vs model",
                irq, m_cos && cos_irq_en && blk_irq_en);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // One frame: strobe cycle, then an idle cycle carrying unqualified yellow (R4).
    task automatic frame(input bit mf, input bit yel);
        frame_stb = 1; mf_start = mf; yel_bit = yel;
        step();
        frame_stb = 0; mf_start = 1; yel_bit = 1;
        step();
        mf_start = 0; yel_bit = 0;
    endtask

    // pat: 0 no yellow, 1 yellow on both multiframe starts, 2 only on frame 16,
    // 3 yellow on every frame but never with mf_start.
    task automatic windows(input int n, input int pat);
        for (int w = 0; w < n; w++)
            for (int f = 0; f < 32; f++) begin
                bit mfs;
                mfs = (f == 0 || f == 16) && pat != 3;
                frame(mfs, (pat == 1 && mfs) || (pat == 2 && f == 16) || pat == 3);
            end
    endtask

    task automatic settle();
        for (int i = 0; i < 3; i++) step();
    endtask

    initial begin
        #(PER * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        @(negedge clk);
        chk(alarm === 0 && cos_flag === 0 && irq === 0, "R9 reset state", {alarm, cos_flag, irq}, 0);
        step();
        rst_n = 1; cos_irq_en = 1; blk_irq_en = 1; rur_mode = 1;

        windows(79, 1);
        settle();
        chk(alarm === 0, "R2 not declared at 79", alarm, 0);
        windows(1, 2);
        settle();
        chk(alarm === 1, "R1 frame-16-only window counts, R2 declared at 80", alarm, 1);
        chk(cos_flag === 1, "R5 flag set on declare", cos_flag, 1);
        chk(irq === 1, "R8 irq with both enables", irq, 1);
        blk_irq_en = 0; #1;
        chk(irq === 0, "R8 irq gated by block enable", irq, 0);
        blk_irq_en = 1; cos_irq_en = 0; #1;
        chk(irq === 0, "R8 irq gated by alarm enable", irq, 0);
        cos_irq_en = 1;

        rur_mode = 0; stat_rd = 1; step(); stat_rd = 0; step();
        chk(cos_flag === 1, "R6 read ignored without clear-on-read", cos_flag, 1);
        stat_wr = 1; stat_wdata = 0; step(); stat_wr = 0; step();
        chk(cos_flag === 1, "R6 write of zero ignored", cos_flag, 1);
        stat_wr = 1; stat_wdata = 1; step(); stat_wr = 0; stat_wdata = 0; step();
        chk(cos_flag === 0, "R6 write of one clears", cos_flag, 0);

        windows(5, 1);
        windows(10, 0);
        settle();
        chk(alarm === 1, "R3 alarm held at count 70", alarm, 1);
        windows(10, 1);
        windows(79, 3);
        settle();
        chk(alarm === 1, "R4 unqualified yellow ignored, R3 held at 1", alarm, 1);
        chk(cos_flag === 0, "R5 no change while held", cos_flag, 0);

        rur_mode = 1; stat_rd = 1;
        windows(1, 0);
        begin
            int guard = 0;
            @(negedge clk);
            while (alarm !== 0 && guard < 10) begin @(negedge clk); guard++; end
            chk(alarm === 0, "R3 removed at zero", alarm, 0);
            @(negedge clk);
            chk(cos_flag === 1, "R7 set beats clear-on-read", cos_flag, 1);
            @(negedge clk);
            chk(cos_flag === 0, "R6 read clears in clear-on-read mode", cos_flag, 0);
        end
        step(); stat_rd = 0;

        windows(50, 1);
        rst_n = 0; step(); step();
        @(negedge clk);
        chk(alarm === 0 && cos_flag === 0 && irq === 0, "R9 mid-run reset", {alarm, cos_flag, irq}, 0);
        step(); rst_n = 1;
        windows(30, 1);
        settle();
        chk(alarm === 0, "R9 integrator restarted by reset", alarm, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule